// File: doc/BRIEF.md
# Nibble-RAM Call/Return Context Stack

This block keeps the return context of a small 4-bit processor during subroutine calls and accepted interrupts. It does not hold a private LIFO array. The stack lives in a window of the shared nibble-wide data RAM, between addresses 040h and 0FFh. An 8-bit stack pointer decides where each frame is placed. A frame takes four consecutive nibbles and holds a 13-bit return program counter together with the zero and carry flags.

A push request captures the context and writes the frame one nibble per clock through a single-port RAM port. After the fourth write, the pointer moves down by four. A pop request first moves the pointer up by four. It then reads the same four nibbles back and presents the restored program counter with a one-cycle done pulse. A plain return restores only the program counter. A return from interrupt restores the flags as well.

Requests that would leave the window are refused. Each refusal raises a sticky error flag, and the pointer does not move.

Top module: `ctx_stack`

## Requirements
- R1: After reset the pointer `spOut` reads 0FFh. `busy`, `popDone`, `overflow`, `underflow`, `pcOut`, `zOut` and `cOut` all read zero.
- R2: An accepted push writes four nibbles on consecutive cycles, at addresses SP, SP-1, SP-2 and SP-3 in that order. SP is the pointer value at acceptance. The nibble at SP holds PC[3:0], the nibble at SP-1 holds PC[7:4], and the nibble at SP-2 holds PC[11:8].
- R3: A push moves the pointer down by exactly 4. The new value appears in the cycle after the fourth write.
- R4: An accepted pop moves the pointer up by 4 in the cycle after acceptance. It then reads the new SP, SP-1, SP-2 and SP-3 on four consecutive cycles. One cycle after the last read cycle, `popDone` pulses for one cycle and `pcOut` holds the restored counter.
- R5: When `popRestoreFlags` is low at acceptance, the pop leaves `zOut` and `cOut` unchanged. When it is high, the pop loads them from the frame.
- R6: `busy` stays high for exactly 4 cycles on a push and 5 cycles on a pop. Push and pop requests that arrive while `busy` is high are ignored.
- R7: A push requested while SP is below 043h, so that the frame would reach below 040h, is refused. The refusal sets a sticky `overflow` flag. The RAM is not written, `busy` stays low and the pointer is unchanged.
- R8: A pop requested while SP is 0FFh is refused. The refusal sets a sticky `underflow` flag. The RAM is not read, `busy` stays low, no `popDone` occurs and the pointer is unchanged.
- R9: When push and pop are requested in the same idle cycle, only the push is performed.
- R10: The nibble at SP-3 holds Z in bit 3, C in bit 2 and PC[12] in bit 1. Bit 0 of that nibble is always written as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pushReq | input | 1 | Save-context request (call or interrupt entry) |
| popReq | input | 1 | Restore-context request (return) |
| popRestoreFlags | input | 1 | With popReq: also restore Z and C |
| pcIn | input | 13 | Return program counter to save |
| zIn | input | 1 | Zero flag to save |
| cIn | input | 1 | Carry flag to save |
| busy | output | 1 | A push or pop sequence is running |
| popDone | output | 1 | One-cycle pulse when the restored context is valid |
| pcOut | output | 13 | Restored program counter |
| zOut | output | 1 | Restored zero flag |
| cOut | output | 1 | Restored carry flag |
| spOut | output | 8 | Current stack pointer |
| overflow | output | 1 | Sticky: a push was refused |
| underflow | output | 1 | Sticky: a pop was refused |
| ramAddr | output | 8 | Nibble RAM address |
| ramWe | output | 1 | Nibble RAM write enable |
| ramRe | output | 1 | Nibble RAM read enable (data one cycle later) |
| ramWdata | output | 4 | Nibble RAM write data |
| ramRdata | input | 4 | Nibble RAM read data |

## Verification
The embedded assertions check, on every cycle, the properties that hold locally:

- The pointer only ever changes by plus or minus four.
- The pointer stays aligned inside the window.
- Every RAM access lands at or above 040h.
- Both error flags stay set once raised.
- A running sequence is never replaced by a new request.
- The done pulse follows the last pop cycle.

Other behaviour needs the bench's scenarios and its reference queue and RAM model. That covers the packing of each nibble, the order of writes and reads, and the restored values after nested calls and returns. It also covers the difference between a plain return and a return from interrupt, and the refusal of a push at a full stack and of a pop at an empty one.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;
  localparam int PC_W       = 13;
  localparam int ADDR_W     = 8;
  localparam int NIB_W      = 4;
  localparam int FRAME_NIBS = 4;
  localparam int FRAME_W    = FRAME_NIBS * NIB_W;
  localparam int SLOT_W     = $clog2(FRAME_NIBS);
  localparam int PH_W       = $clog2(FRAME_NIBS + 1);
  localparam logic [ADDR_W-1:0] SP_TOP   = 8'hFF;
  localparam logic [ADDR_W-1:0] SP_FLOOR = 8'h40;

  typedef struct packed {
    logic              latch;        // capture context for a push
    logic              wrEn;         // write one frame nibble
    logic              rdEn;         // read one frame nibble
    logic [SLOT_W-1:0] slot;         // nibble index below SP for access
    logic              capEn;        // capture returning read data
    logic [SLOT_W-1:0] capSlot;      // nibble index of returning data
    logic              spDec;        // move pointer down one frame
    logic              spInc;        // move pointer up one frame
    logic              commit;       // publish restored context
    logic              restoreFlags; // commit also loads Z and C
    logic              setOvf;       // refused push
    logic              setUnf;       // refused pop
  } strobe_t;
endpackage

// File: rtl/ctx_stack_ctrl.sv
module ctx_stack_ctrl
  import ctx_stack_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    pushReq,
  input  logic    popReq,
  input  logic    withFlags,
  input  logic    spAtTop,
  input  logic    spNoRoom,
  output strobe_t strb,
  output logic    busy,
  output logic    popDone
);
  typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_POP} state_t;

  state_t            state;
  logic [PH_W-1:0]   phase;
  logic [PH_W-1:0]   phaseM1;
  logic              modeFlags;
  logic              isIdle, acceptPush, acceptPop, lastPush, lastPop;

  assign isIdle     = (state == ST_IDLE);
  assign acceptPush = isIdle && pushReq && !spNoRoom;
  assign acceptPop  = isIdle && !pushReq && popReq && !spAtTop;
  assign lastPush   = (state == ST_PUSH) && (phase == PH_W'(FRAME_NIBS - 1));
  assign lastPop    = (state == ST_POP)  && (phase == PH_W'(FRAME_NIBS));
  assign phaseM1    = phase - 1'b1;
  assign busy       = !isIdle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phase     <= '0;
      modeFlags <= 1'b0;
      popDone   <= 1'b0;
    end else begin
      popDone <= lastPop;
      unique case (state)
        ST_IDLE: begin
          phase <= '0;
          if (acceptPush) begin
            state <= ST_PUSH;
          end else if (acceptPop) begin
            state     <= ST_POP;
            modeFlags <= withFlags;
          end
        end
        ST_PUSH: begin
          phase <= phase + 1'b1;
          if (lastPush) state <= ST_IDLE;
        end
        ST_POP: begin
          phase <= phase + 1'b1;
          if (lastPop) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb              = '0;
    strb.latch        = acceptPush;
    strb.setOvf       = isIdle && pushReq && spNoRoom;
    strb.spInc        = acceptPop;
    strb.setUnf       = isIdle && !pushReq && popReq && spAtTop;
    strb.slot         = phase[SLOT_W-1:0];
    strb.wrEn         = (state == ST_PUSH);
    strb.spDec        = lastPush;
    strb.rdEn         = (state == ST_POP) && (phase < PH_W'(FRAME_NIBS));
    strb.capEn        = (state == ST_POP) && (phase != '0);
    strb.capSlot      = phaseM1[SLOT_W-1:0];
    strb.commit       = lastPop;
    strb.restoreFlags = modeFlags;
  end

  // R6: a running sequence continues unchanged whatever the request inputs do
  assert_ignore_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastPush && !lastPop) |=> (busy && state == $past(state)))
    else $error("sequence disturbed while busy");

  // R4: the final pop cycle is followed by the done pulse in an idle cycle
  assert_pop_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    lastPop |=> (popDone && !busy))
    else $error("pop done pulse missing");

  // R4: done is a single-cycle pulse
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    popDone |=> !popDone)
    else $error("pop done longer than one cycle");
endmodule

// File: rtl/ctx_stack_dp.sv
module ctx_stack_dp
  import ctx_stack_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [PC_W-1:0]   pcIn,
  input  logic              zIn,
  input  logic              cIn,
  input  logic [NIB_W-1:0]  ramRdata,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [NIB_W-1:0]  ramWdata,
  output logic [ADDR_W-1:0] spOut,
  output logic              spAtTop,
  output logic              spNoRoom,
  output logic [PC_W-1:0]   pcOut,
  output logic              zOut,
  output logic              cOut,
  output logic              overflow,
  output logic              underflow
);
  localparam logic [ADDR_W-1:0] SP_STEP   = ADDR_W'(FRAME_NIBS);
  localparam logic [ADDR_W-1:0] LOW_LIMIT = SP_FLOOR + ADDR_W'(FRAME_NIBS - 1);

  logic [ADDR_W-1:0]  spReg;
  logic [FRAME_W-1:0] frameQ;
  logic [FRAME_W-1:0] readQ;
  logic [NIB_W-1:0]   nibNow [FRAME_NIBS];

  assign spOut    = spReg;
  assign spAtTop  = (spReg == SP_TOP);
  assign spNoRoom = (spReg < LOW_LIMIT);
  assign ramAddr  = spReg - {{(ADDR_W-SLOT_W){1'b0}}, strb.slot};
  assign ramWdata = frameQ[strb.slot*NIB_W +: NIB_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spReg <= SP_TOP;
    end else if (strb.spDec) begin
      spReg <= spReg - SP_STEP;
    end else if (strb.spInc) begin
      spReg <= spReg + SP_STEP;
    end
  end

  // frame layout, nibble 0 at SP: PC low, mid, high, then {Z, C, PC12, 0}
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameQ <= '0;
    end else if (strb.latch) begin
      frameQ <= {zIn, cIn, pcIn[PC_W-1], 1'b0, pcIn[PC_W-2:0]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readQ <= '0;
    end else begin
      for (int i = 0; i < FRAME_NIBS; i++) begin
        if (strb.capEn && strb.capSlot == SLOT_W'(i)) readQ[i*NIB_W +: NIB_W] <= ramRdata;
      end
    end
  end

  for (genvar g = 0; g < FRAME_NIBS; g++) begin : g_nib
    assign nibNow[g] = (strb.capEn && strb.capSlot == SLOT_W'(g)) ? ramRdata
                                                                  : readQ[g*NIB_W +: NIB_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcOut <= '0;
      zOut  <= 1'b0;
      cOut  <= 1'b0;
    end else if (strb.commit) begin
      pcOut <= {nibNow[3][1], nibNow[2], nibNow[1], nibNow[0]};
      if (strb.restoreFlags) begin
        zOut <= nibNow[3][3];
        cOut <= nibNow[3][2];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (strb.setOvf) overflow  <= 1'b1;
      if (strb.setUnf) underflow <= 1'b1;
    end
  end

  // R3: the pointer only ever moves by one frame
  assert_sp_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(spReg) |-> (spReg == $past(spReg) - SP_STEP || spReg == $past(spReg) + SP_STEP))
    else $error("pointer moved by other than a frame");

  // R7: pointer stays frame-aligned and never drops below one frame under the floor
  assert_sp_window_R7: assert property (@(posedge clk) disable iff (!rstN)
    (spReg[SLOT_W-1:0] == {SLOT_W{1'b1}}) && (spReg >= SP_FLOOR - 8'd1))
    else $error("pointer outside window");

  // R7: no RAM access ever lands below the stack floor
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn || strb.rdEn) |-> (ramAddr >= SP_FLOOR))
    else $error("frame access below floor");

  // R7: overflow is sticky
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow)
    else $error("overflow flag cleared");

  // R8: underflow is sticky
  assert_unf_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> underflow)
    else $error("underflow flag cleared");
endmodule

// File: rtl/ctx_stack.sv
module ctx_stack
  import ctx_stack_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushReq,
  input  logic              popReq,
  input  logic              popRestoreFlags,
  input  logic [PC_W-1:0]   pcIn,
  input  logic              zIn,
  input  logic              cIn,
  output logic              busy,
  output logic              popDone,
  output logic [PC_W-1:0]   pcOut,
  output logic              zOut,
  output logic              cOut,
  output logic [ADDR_W-1:0] spOut,
  output logic              overflow,
  output logic              underflow,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramWe,
  output logic              ramRe,
  output logic [NIB_W-1:0]  ramWdata,
  input  logic [NIB_W-1:0]  ramRdata
);
  strobe_t strb;
  logic    spAtTop, spNoRoom;

  ctx_stack_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pushReq   (pushReq),
    .popReq    (popReq),
    .withFlags (popRestoreFlags),
    .spAtTop   (spAtTop),
    .spNoRoom  (spNoRoom),
    .strb      (strb),
    .busy      (busy),
    .popDone   (popDone)
  );

  ctx_stack_dp i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .pcIn      (pcIn),
    .zIn       (zIn),
    .cIn       (cIn),
    .ramRdata  (ramRdata),
    .ramAddr   (ramAddr),
    .ramWdata  (ramWdata),
    .spOut     (spOut),
    .spAtTop   (spAtTop),
    .spNoRoom  (spNoRoom),
    .pcOut     (pcOut),
    .zOut      (zOut),
    .cOut      (cOut),
    .overflow  (overflow),
    .underflow (underflow)
  );

  assign ramWe = strb.wrEn;
  assign ramRe = strb.rdEn;
endmodule

// File: tb/test_ctx_stack.sv
`timescale 1ns/1ps
module test_ctx_stack;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pushReq = 1'b0, popReq = 1'b0, popRestoreFlags = 1'b0;
  logic [12:0] pcIn = '0;
  logic        zIn = 1'b0, cIn = 1'b0;
  logic        busy, popDone, zOut, cOut, overflow, underflow, ramWe, ramRe;
  logic [12:0] pcOut;
  logic [7:0]  spOut, ramAddr;
  logic [3:0]  ramWdata, ramRdata;

  always #2.5 clk = ~clk;

  ctx_stack i_ctx_stack (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .popReq(popReq),
    .popRestoreFlags(popRestoreFlags), .pcIn(pcIn), .zIn(zIn), .cIn(cIn),
    .busy(busy), .popDone(popDone), .pcOut(pcOut), .zOut(zOut), .cOut(cOut),
    .spOut(spOut), .overflow(overflow), .underflow(underflow),
    .ramAddr(ramAddr), .ramWe(ramWe), .ramRe(ramRe), .ramWdata(ramWdata),
    .ramRdata(ramRdata)
  );

  // nibble RAM model with one cycle read latency, plus access logs
  logic [3:0] mem [256];
  logic [7:0] wrAddr [1024];
  logic [3:0] wrData [1024];
  logic [7:0] rdAddr [1024];
  int wrTotal = 0, rdTotal = 0;
  initial for (int i = 0; i < 256; i++) mem[i] = 4'h0;
  initial ramRdata = 4'h0;
  always @(posedge clk) begin
    if (ramWe) begin
      mem[ramAddr] <= ramWdata;
      wrAddr[wrTotal % 1024] <= ramAddr;
      wrData[wrTotal % 1024] <= ramWdata;
      wrTotal <= wrTotal + 1;
    end
    if (ramRe) begin
      rdAddr[rdTotal % 1024] <= ramAddr;
      rdTotal <= rdTotal + 1;
    end
    ramRdata <= mem[ramAddr];
  end

  typedef struct { logic [12:0] pc; logic z; logic c; } frame_t;
  frame_t refQ[$];
  int total = 0, bad = 0;
  int expSp = 255;
  logic expZ = 1'b0, expC = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] nib(input logic [12:0] pc, input logic z, input logic c, input int k);
    case (k)
      0: nib = pc[3:0];
      1: nib = pc[7:4];
      2: nib = pc[11:8];
      default: nib = {z, c, pc[12], 1'b0};
    endcase
  endfunction

  // push; alsoPop asks for a pop in the same cycle (R9); poke disturbs mid-sequence (R6)
  task automatic doPush(input logic [12:0] pc, input logic z, input logic c, input logic alsoPop, input logic poke);
    int w0;
    w0 = wrTotal;
    @(negedge clk);
    pushReq = 1'b1; popReq = alsoPop; pcIn = pc; zIn = z; cIn = c;
    @(negedge clk);
    pushReq = 1'b0; popReq = 1'b0;
    chk("R6", "busy first push cycle", busy, 1);
    @(negedge clk);
    if (poke) begin popReq = 1'b1; pushReq = 1'b1; end
    @(negedge clk);
    popReq = 1'b0; pushReq = 1'b0;
    @(negedge clk);
    chk("R6", "busy last push cycle", busy, 1);
    @(negedge clk);
    chk("R6", "busy after push", busy, 0);
    chk("R3", "sp after push", spOut, expSp - 4);
    chk("R2", "write count", wrTotal - w0, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R2", "write address", wrAddr[(w0 + k) % 1024], expSp - k);
      chk(k == 3 ? "R10" : "R2", "write nibble", wrData[(w0 + k) % 1024], nib(pc, z, c, k));
    end
    expSp -= 4;
    refQ.push_back('{pc: pc, z: z, c: c});
  endtask

  task automatic doPop(input logic rtni);
    frame_t e;
    int r0;
    e = refQ.pop_back();
    r0 = rdTotal;
    @(negedge clk);
    popReq = 1'b1; popRestoreFlags = rtni;
    @(negedge clk);
    popReq = 1'b0; popRestoreFlags = 1'b0;
    expSp += 4;
    chk("R4", "sp raised at pop start", spOut, expSp);
    chk("R6", "busy first pop cycle", busy, 1);
    repeat (4) @(negedge clk);
    chk("R6", "busy last pop cycle", busy, 1);
    chk("R4", "no early done", popDone, 0);
    @(negedge clk);
    chk("R4", "pop done pulse", popDone, 1);
    chk("R6", "busy after pop", busy, 0);
    chk("R4", "restored pc", pcOut, e.pc);
    if (rtni) begin expZ = e.z; expC = e.c; end
    chk("R5", "z after return", zOut, expZ);
    chk("R5", "c after return", cOut, expC);
    chk("R4", "read count", rdTotal - r0, 4);
    for (int k = 0; k < 4; k++) chk("R4", "read address", rdAddr[(r0 + k) % 1024], expSp - k);
    @(negedge clk);
    chk("R4", "done lasts one cycle", popDone, 0);
  endtask

  // op: 1 push, 2 pop; then rtni, pc, z, c
  localparam logic [17:0] VEC [10] = '{
    {2'd1, 1'b0, 13'h1ABC, 1'b1, 1'b0},
    {2'd1, 1'b0, 13'h0123, 1'b0, 1'b1},
    {2'd2, 1'b0, 13'h0000, 1'b0, 1'b0},
    {2'd1, 1'b0, 13'h1F0F, 1'b1, 1'b1},
    {2'd1, 1'b0, 13'h0A55, 1'b0, 1'b1},
    {2'd2, 1'b1, 13'h0000, 1'b0, 1'b0},
    {2'd2, 1'b1, 13'h0000, 1'b0, 1'b0},
    {2'd2, 1'b0, 13'h0000, 1'b0, 1'b0},
    {2'd1, 1'b0, 13'h1001, 1'b1, 1'b0},
    {2'd2, 1'b1, 13'h0000, 1'b0, 1'b0}
  };

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w0, r0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "reset sp", spOut, 8'hFF);
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset done", popDone, 0);
    chk("R1", "reset flags", {overflow, underflow}, 0);
    chk("R1", "reset context", {pcOut, zOut, cOut}, 0);

    foreach (VEC[i]) begin
      if (VEC[i][17:16] == 2'd1) doPush(VEC[i][14:2], VEC[i][1], VEC[i][0], 1'b0, 1'b0);
      else doPop(VEC[i][15]);
    end

    // R6: requests during a push are ignored
    doPush(13'h0777, 1'b1, 1'b1, 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    chk("R6", "no extra op after busy", busy, 0);
    chk("R6", "sp intact after ignored request", spOut, expSp);
    // R9: push wins over pop in the same cycle
    doPush(13'h0888, 1'b0, 1'b0, 1'b1, 1'b0);
    doPop(1'b1);
    doPop(1'b0);

    // R7: fill the window, then one push too many
    while (expSp >= 8'h43) doPush(13'(expSp * 37), expSp[2], expSp[3], 1'b0, 1'b0);
    chk("R7", "sp at full stack", spOut, 8'h3F);
    w0 = wrTotal;
    @(negedge clk); pushReq = 1'b1; pcIn = 13'h1234;
    @(negedge clk); pushReq = 1'b0;
    chk("R7", "refused push not busy", busy, 0);
    chk("R7", "overflow set", overflow, 1);
    @(negedge clk);
    chk("R7", "sp unchanged", spOut, 8'h3F);
    chk("R7", "no write", wrTotal - w0, 0);

    while (refQ.size() > 0) doPop(refQ.size() % 2 == 0);
    chk("R8", "sp at empty", spOut, 8'hFF);
    r0 = rdTotal;
    @(negedge clk); popReq = 1'b1;
    @(negedge clk); popReq = 1'b0;
    chk("R8", "refused pop not busy", busy, 0);
    chk("R8", "underflow set", underflow, 1);
    repeat (6) begin
      @(negedge clk);
      chk("R8", "no done on refused pop", popDone, 0);
    end
    chk("R8", "sp unchanged", spOut, 8'hFF);
    chk("R8", "no read", rdTotal - r0, 0);
    chk("R7", "overflow still set", overflow, 1);

    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "flags cleared by reset", {overflow, underflow}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule